// File: doc/BRIEF.md
# Sample FIFO with Word-Addressed Status Port

This block is a single-clock FIFO that sits between a streaming sample producer and a consumer. Each side uses a valid/ready handshake. The write side is refused while the queue is full. The read side always shows the oldest stored sample while anything is held.

A host reaches the FIFO through a 32-bit word-addressed register port with address, read, write, writedata and readdata signals. Through this port the host can:
- read the current occupancy;
- read a status word of six active-high condition flags;
- set the two threshold levels behind the near-full and near-empty flags.

Refused pushes and pops are recorded in two sticky error flags. The host clears each of them by writing a one to its bit. A host that uses byte addresses reaches the same registers at steps of four.

Top module: `sample_fifo_csr`

## Requirements
- R1: A read at word offset 0 returns the current fill level, zero-extended to 32 bits.
- R2: A read at word offset 1 returns the status word. Bit 0 is full (level equals depth), bit 1 is empty (level zero), bit 2 is almost-full, bit 3 is almost-empty, bit 4 is overflow and bit 5 is underflow. Bits 31 to 6 read as zero.
- R3: The FIFO handshake works as follows:
  - in_ready is high exactly when the FIFO is not full, and a sample is stored when in_valid and in_ready are both high.
  - out_valid is high exactly when the FIFO is not empty, and out_data shows the oldest stored sample.
  - A sample is removed when out_valid and out_ready are both high.
  - Samples leave in the order they arrived.
- R4: A push and a pop accepted in the same cycle leave the fill level unchanged.
- R5: When in_valid is high while the FIFO is full, the sample is discarded and overflow (bit 4) is set. This holds even if a pop happens in the same cycle.
- R6: When out_ready is high while the FIFO is empty, underflow (bit 5) is set and the stored contents do not change.
- R7: Overflow and underflow stay set until the host writes offset 1 with a one in the matching bit. A zero in that bit leaves the flag as it is. A new event in the same cycle as a clear leaves the flag set.
- R8: Offset 2 holds the almost-full threshold and offset 3 holds the almost-empty threshold. Both are writable from the low bits of writedata, read back what was written, and reset to depth minus 2 and 2.
- R9: Almost-full is high when the fill level is at or above its threshold. Almost-empty is high when the fill level is at or below its threshold.
- R10: Register reads behave as follows:
  - readdata is registered and is valid in the cycle after read is asserted.
  - It reflects the state as it was before that clock edge.
  - Offsets 4 to 7 read as zero.
  - Writes to offsets 0 and 4 to 7 have no effect.
- R11: After reset the FIFO is empty, both sticky flags are clear and the thresholds hold their reset values. Offset 1 therefore reads 0x0A with the default depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer has a sample |
| in_ready | output | 1 | FIFO can accept a sample |
| in_data | input | DATA_W | Producer sample |
| out_valid | output | 1 | FIFO holds a sample |
| out_ready | input | 1 | Consumer takes the sample |
| out_data | output | DATA_W | Oldest stored sample |
| csr_addr | input | CSR_AW | Word address of the register port |
| csr_read | input | 1 | Register read strobe |
| csr_write | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Registered read data |

## Verification
The hardest situation to create from the ports is a new overflow or underflow event landing in the same cycle as the host's clear of that flag. A related case is a push and a pop together on a full FIFO, where only the pop is taken. The directed stimulus holds out_ready on an empty FIFO while writing the clear to offset 1 in that same cycle. It also fills the queue to depth and then drives both handshakes at once. A long randomized phase then mixes traffic, reads of every offset, clears and threshold rewrites. All of it is compared against a queue-based model on every clock.

// File: rtl/fifo_csr_pkg.sv
package fifo_csr_pkg;
    localparam int OFS_LEVEL  = 0;
    localparam int OFS_STATUS = 1;
    localparam int OFS_HI_THR = 2;
    localparam int OFS_LO_THR = 3;

    localparam int ST_FULL   = 0;
    localparam int ST_EMPTY  = 1;
    localparam int ST_HI     = 2;
    localparam int ST_LO     = 3;
    localparam int ST_OVFL   = 4;
    localparam int ST_UNDFL  = 5;
    localparam int ST_BITS   = 6;
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    always_comb rdata = mem_q[raddr];
endmodule

// File: rtl/fifo_ptrs.sv
module fifo_ptrs #(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             ovf_evt,
    output logic             udf_evt,
    output logic             full,
    output logic             empty,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [LVL_W-1:0] level
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [LVL_W-1:0] lvl;
    } ptr_state_t;

    ptr_state_t s_d, s_q;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        full    = (s_q.lvl == LVL_W'(DEPTH));
        empty   = (s_q.lvl == '0);
        push_ok = push_req && !full;
        pop_ok  = pop_req && !empty;
        ovf_evt = push_req && full;
        udf_evt = pop_req && empty;
        if (push_ok) s_d.wr = wrap_inc(s_q.wr);
        if (pop_ok)  s_d.rd = wrap_inc(s_q.rd);
        case ({push_ok, pop_ok})
            2'b10:   s_d.lvl = s_q.lvl + 1'b1;
            2'b01:   s_d.lvl = s_q.lvl - 1'b1;
            default: s_d.lvl = s_q.lvl;
        endcase
        wr_ptr = s_q.wr;
        rd_ptr = s_q.rd;
        level  = s_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lvl <= LVL_W'(DEPTH));
    p_both_hold_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !full && !empty) |=> $stable(s_q.lvl));
    p_full_no_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full) |=> (s_q.lvl <= $past(s_q.lvl)));
    p_empty_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty) |=> $stable(s_q.rd));
endmodule

// File: rtl/fifo_csr.sv
module fifo_csr
    import fifo_csr_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int LVL_W  = $clog2(DEPTH + 1),
    parameter int CSR_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  level,
    input  logic              full,
    input  logic              empty,
    input  logic              ovf_evt,
    input  logic              udf_evt,
    input  logic [CSR_AW-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    typedef struct packed {
        logic [LVL_W-1:0] hi_thr;
        logic [LVL_W-1:0] lo_thr;
        logic             ovf;
        logic             udf;
        logic [31:0]      rdata;
    } csr_state_t;

    localparam logic [LVL_W-1:0] HI_RST = LVL_W'(DEPTH - 2);
    localparam logic [LVL_W-1:0] LO_RST = LVL_W'(2);

    csr_state_t c_d, c_q;
    logic [ST_BITS-1:0] stat;
    logic               clr_ovf, clr_udf;
    logic               unused_wbits;

    assign unused_wbits = ^wdata[31:LVL_W];

    always_comb begin
        c_d = c_q;
        stat           = '0;
        stat[ST_FULL]  = full;
        stat[ST_EMPTY] = empty;
        stat[ST_HI]    = (level >= c_q.hi_thr);
        stat[ST_LO]    = (level <= c_q.lo_thr);
        stat[ST_OVFL]  = c_q.ovf;
        stat[ST_UNDFL] = c_q.udf;

        clr_ovf = wr && (addr == CSR_AW'(OFS_STATUS)) && wdata[ST_OVFL];
        clr_udf = wr && (addr == CSR_AW'(OFS_STATUS)) && wdata[ST_UNDFL];
        c_d.ovf = (c_q.ovf && !clr_ovf) || ovf_evt;
        c_d.udf = (c_q.udf && !clr_udf) || udf_evt;

        if (wr && addr == CSR_AW'(OFS_HI_THR)) c_d.hi_thr = wdata[LVL_W-1:0];
        if (wr && addr == CSR_AW'(OFS_LO_THR)) c_d.lo_thr = wdata[LVL_W-1:0];

        if (rd) begin
            case (int'(addr))
                OFS_LEVEL:  c_d.rdata = 32'(level);
                OFS_STATUS: c_d.rdata = 32'(stat);
                OFS_HI_THR: c_d.rdata = 32'(c_q.hi_thr);
                OFS_LO_THR: c_d.rdata = 32'(c_q.lo_thr);
                default:    c_d.rdata = '0;
            endcase
        end
        rdata = c_q.rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.hi_thr <= HI_RST;
            c_q.lo_thr <= LO_RST;
            c_q.ovf    <= 1'b0;
            c_q.udf    <= 1'b0;
            c_q.rdata  <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    p_ovf_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> c_q.ovf);
    p_udf_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        udf_evt |=> c_q.udf);
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ovf && !(wr && addr == CSR_AW'(OFS_STATUS) && wdata[ST_OVFL])) |=> c_q.ovf);
    p_udf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.udf && !(wr && addr == CSR_AW'(OFS_STATUS) && wdata[ST_UNDFL])) |=> c_q.udf);
    p_status_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == CSR_AW'(OFS_STATUS)) |=> (rdata[31:ST_BITS] == '0));
    p_undef_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr > CSR_AW'(OFS_LO_THR)) |=> (rdata == '0));
endmodule

// File: rtl/sample_fifo_csr.sv
module sample_fifo_csr #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int CSR_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic              csr_read,
    input  logic              csr_write,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             push_ok, pop_ok, ovf_evt, udf_evt, full, empty;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] level;

    fifo_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) ptrs_i (
        .clk(clk), .rst_n(rst_n),
        .push_req(in_valid), .pop_req(out_ready),
        .push_ok(push_ok), .pop_ok(pop_ok),
        .ovf_evt(ovf_evt), .udf_evt(udf_evt),
        .full(full), .empty(empty),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level)
    );

    fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) store_i (
        .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(in_data),
        .raddr(rd_ptr), .rdata(out_data)
    );

    fifo_csr #(.DEPTH(DEPTH), .LVL_W(LVL_W), .CSR_AW(CSR_AW)) csr_i (
        .clk(clk), .rst_n(rst_n),
        .level(level), .full(full), .empty(empty),
        .ovf_evt(ovf_evt), .udf_evt(udf_evt),
        .addr(csr_addr), .rd(csr_read), .wr(csr_write), .wdata(csr_wdata),
        .rdata(csr_rdata)
    );

    assign in_ready  = !full;
    assign out_valid = !empty;

    p_pop_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |-> out_valid);
endmodule

// File: tb/sample_fifo_csr_tb_top.sv
`timescale 1ns/1ps
module sample_fifo_csr_tb_top;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 16;
    localparam int CSR_AW = 3;
    localparam int LVL_W  = $clog2(DEPTH + 1);

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, out_ready = 0, csr_read = 0, csr_write = 0;
    logic in_ready, out_valid;
    logic [DATA_W-1:0] in_data = '0, out_data;
    logic [CSR_AW-1:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0, csr_rdata;

    always #2.5 clk = ~clk;

    sample_fifo_csr #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CSR_AW(CSR_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .csr_addr(csr_addr), .csr_read(csr_read),
        .csr_write(csr_write), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
    );

    int checks = 0, fails = 0;
    logic [DATA_W-1:0] q[$];
    int hi_m = DEPTH - 2, lo_m = 2;
    bit ovf_m = 0, udf_m = 0;
    logic [31:0] last_rd;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_status();
        logic [31:0] s = '0;
        int c = q.size();
        s[0] = (c == DEPTH);
        s[1] = (c == 0);
        s[2] = (c >= hi_m);
        s[3] = (c <= lo_m);
        s[4] = ovf_m;
        s[5] = udf_m;
        return s;
    endfunction

    task automatic step();
        int c = q.size();
        bit rd = csr_read;
        int a = int'(csr_addr);
        logic [31:0] exp = '0;
        string tag;
        bit push_ok, pop_ok, ovf_set, udf_set;
        case (a)
            0: begin exp = 32'(c); tag = "R1"; end
            1: begin exp = model_status(); tag = "R2"; end
            2: begin exp = 32'(hi_m); tag = "R8"; end
            3: begin exp = 32'(lo_m); tag = "R8"; end
            default: begin exp = '0; tag = "R10"; end
        endcase
        @(posedge clk);
        push_ok = in_valid && c < DEPTH;
        pop_ok  = out_ready && c > 0;
        ovf_set = in_valid && c == DEPTH;
        udf_set = out_ready && c == 0;
        if (csr_write && a == 1) begin
            if (csr_wdata[4]) ovf_m = 0;
            if (csr_wdata[5]) udf_m = 0;
        end
        if (csr_write && a == 2) hi_m = int'(csr_wdata[LVL_W-1:0]);
        if (csr_write && a == 3) lo_m = int'(csr_wdata[LVL_W-1:0]);
        if (ovf_set) ovf_m = 1;
        if (udf_set) udf_m = 1;
        if (pop_ok) void'(q.pop_front());
        if (push_ok) q.push_back(in_data);
        @(negedge clk);
        if (rd) begin
            last_rd = csr_rdata;
            chk(csr_rdata == exp, tag, csr_rdata, exp);
        end
        chk(in_ready == (q.size() < DEPTH), "R3", 32'(in_ready), 32'(q.size() < DEPTH));
        chk(out_valid == (q.size() > 0), "R3", 32'(out_valid), 32'(q.size() > 0));
        if (q.size() > 0) chk(out_data == q[0], "R3", 32'(out_data), 32'(q[0]));
    endtask

    task automatic idle();
        in_valid = 0; out_ready = 0; csr_read = 0; csr_write = 0;
    endtask

    task automatic reg_rd(input int a);
        csr_addr = CSR_AW'(a); csr_read = 1;
        step();
        csr_read = 0;
    endtask

    task automatic reg_wr(input int a, input logic [31:0] d);
        csr_addr = CSR_AW'(a); csr_wdata = d; csr_write = 1;
        step();
        csr_write = 0;
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1; in_data = DATA_W'(16'h100 + i);
            step();
        end
        in_valid = 0;
    endtask

    task automatic pop_n(input int n);
        for (int i = 0; i < n; i++) begin
            out_ready = 1;
            step();
        end
        out_ready = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        chk(in_ready == 1, "R11", 32'(in_ready), 1);
        chk(out_valid == 0, "R11", 32'(out_valid), 0);
        for (int a = 0; a < 8; a++) reg_rd(a);
        reg_rd(1); chk(last_rd == 32'h0A, "R11", last_rd, 32'h0A);
        reg_rd(2); chk(last_rd == DEPTH - 2, "R11", last_rd, DEPTH - 2);
        reg_rd(3); chk(last_rd == 2, "R11", last_rd, 2);

        // fill to full
        push_n(DEPTH);
        reg_rd(0); chk(last_rd == DEPTH, "R1", last_rd, DEPTH);
        reg_rd(1); chk(last_rd == 32'h05, "R9", last_rd, 32'h05);

        // overflow
        in_valid = 1; in_data = 16'hDEAD; step(); in_valid = 0;
        reg_rd(1); chk(last_rd[4] == 1, "R5", 32'(last_rd[4]), 1);
        reg_rd(0); chk(last_rd == DEPTH, "R5", last_rd, DEPTH);
        reg_wr(1, 32'h10);
        reg_rd(1); chk(last_rd[4] == 0, "R7", 32'(last_rd[4]), 0);

        // full with push and pop together
        in_valid = 1; out_ready = 1; in_data = 16'hBEEF; step(); idle();
        reg_rd(0); chk(last_rd == DEPTH - 1, "R5", last_rd, DEPTH - 1);
        reg_rd(1); chk(last_rd[4] == 1, "R5", 32'(last_rd[4]), 1);
        reg_wr(1, 32'h0);
        reg_rd(1); chk(last_rd[4] == 1, "R7", 32'(last_rd[4]), 1);

        // simultaneous push/pop mid-level
        for (int i = 0; i < 5; i++) begin
            in_valid = 1; out_ready = 1; in_data = DATA_W'(16'h200 + i); step();
        end
        idle();
        reg_rd(0); chk(last_rd == DEPTH - 1, "R4", last_rd, DEPTH - 1);

        // drain and underflow
        pop_n(DEPTH - 1);
        out_ready = 1; step(); out_ready = 0;
        reg_rd(1); chk(last_rd == 32'h3A, "R6", last_rd, 32'h3A);

        // clear udf in same cycle as new underflow
        out_ready = 1; csr_addr = 1; csr_wdata = 32'h20; csr_write = 1; step(); idle();
        reg_rd(1); chk(last_rd[5] == 1, "R7", 32'(last_rd[5]), 1);
        reg_wr(1, 32'h30);
        reg_rd(1); chk(last_rd == 32'h0A, "R7", last_rd, 32'h0A);

        // thresholds
        reg_wr(2, 32'hFFFF_FFE4);
        reg_wr(3, 32'h1);
        reg_rd(2); chk(last_rd == 4, "R8", last_rd, 4);
        reg_rd(3); chk(last_rd == 1, "R8", last_rd, 1);
        push_n(1); reg_rd(1); chk(last_rd[3:2] == 2'b10, "R9", 32'(last_rd[3:2]), 2);
        push_n(1); reg_rd(1); chk(last_rd[3:2] == 2'b00, "R9", 32'(last_rd[3:2]), 0);
        push_n(1); reg_rd(1); chk(last_rd[3:2] == 2'b00, "R9", 32'(last_rd[3:2]), 0);
        push_n(1); reg_rd(1); chk(last_rd[3:2] == 2'b01, "R9", 32'(last_rd[3:2]), 1);

        // ignored writes
        reg_wr(0, 32'h7);
        reg_wr(5, 32'hFFFF_FFFF);
        reg_rd(0); chk(last_rd == 4, "R10", last_rd, 4);
        reg_rd(2); chk(last_rd == 4, "R10", last_rd, 4);
        reg_rd(6); chk(last_rd == 0, "R10", last_rd, 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            in_valid  = ($urandom_range(0, 99) < 55);
            out_ready = ($urandom_range(0, 99) < 50);
            in_data   = DATA_W'($urandom);
            csr_read  = ($urandom_range(0, 3) == 0);
            csr_write = ($urandom_range(0, 9) == 0);
            csr_addr  = CSR_AW'($urandom_range(0, 7));
            csr_wdata = (csr_addr == 2 || csr_addr == 3) ? 32'($urandom_range(0, DEPTH)) : $urandom;
            step();
        end
        idle();
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule